// File: doc/BRIEF.md
# Receive Byte FIFO with Selectable Low-Water Flag

This block is an eight-entry byte queue on the host side of a display data channel. Two sources can write to it. The slave-side receiver writes bytes directly. When a load-enable input is high, each processor read of the master data buffer also copies that byte into the queue. The processor drains the queue through an 8-bit read port.

The block publishes two level flags, high-water and low-water. The low-water limit is one of four occupancy values, chosen by a 2-bit select. The flags do not follow occupancy directly. After each accepted push or pop, a settle counter restarts, and the flags keep their old values until that counter runs out. When a published flag rises from 0 to 1, a sticky interrupt flag is set. Software clears it with a strobe.

Top module: `rx_level_fifo`

## Requirements
- R1: After reset the queue is empty, flagLow is 1, flagHigh is 0, fifoInt is 0 and popData is 0x00.
- R2: A cycle with slvPush high stores slvData. A cycle with pop high on a non-empty queue presents the oldest stored byte on popData after the next clock edge, so bytes leave in arrival order.
- R3: A cycle with bufRead high and loadEn high stores bufData. With loadEn low, bufRead stores nothing. If slvPush and a buffer load fall in the same cycle, only slvData is stored.
- R4: The queue holds 8 bytes. A push into a full queue with no accepted pop in that cycle is dropped, and the stored contents do not change.
- R5: A pop on an empty queue leaves popData and the queue unchanged.
- R6: When the flags are published, flagHigh becomes 1 if occupancy is 7 or more, and 0 otherwise.
- R7: When the flags are published, flagLow becomes 1 if occupancy is below the limit set by lvlSel: 00 gives 2, 01 gives 3, 10 gives 4, 11 gives 5.
- R8: The flags are published on the SETTLE_CYC-th clock edge after the last accepted push or pop. Before that edge they keep their previous values. Each new accepted push or pop restarts the count.
- R9: fifoInt becomes 1 on the edge where a published flag (flagHigh or flagLow) goes from 0 to 1. It stays at 1 until it is cleared.
- R10: fifoIntClr clears fifoInt on the next edge. If a flag rises on that same edge, the set takes priority and fifoInt stays 1.
- R11: A push and an accepted pop in the same cycle both take effect, and occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slvPush | input | 1 | Slave receiver write strobe |
| slvData | input | 8 | Slave receiver byte |
| bufRead | input | 1 | Processor read of the master data buffer |
| bufData | input | 8 | Byte returned by that buffer read |
| loadEn | input | 1 | Enables copying buffer reads into the queue |
| pop | input | 1 | Processor read strobe for the queue |
| popData | output | 8 | Last byte popped |
| lvlSel | input | 2 | Low-water limit select |
| flagHigh | output | 1 | Published high-water flag |
| flagLow | output | 1 | Published low-water flag |
| fifoIntClr | input | 1 | Clear strobe for the interrupt flag |
| fifoInt | output | 1 | Sticky FIFO interrupt flag |

## Verification
Two events can land on the same clock edge: a flag publish that raises fifoInt, and a software clear of fifoInt. The bench drains the queue so that flagLow will rise at a known edge. It waits SETTLE_CYC-1 cycles after the last pop and then asserts fifoIntClr in the cycle just before the publish. A correct result has fifoInt still at 1 and flagLow newly at 1. A second clear, made on its own, must then bring fifoInt back to 0.

// File: rtl/rx_level_fifo_pkg.sv
package rx_level_fifo_pkg;
  // per-cycle commands from control to datapath
  typedef struct packed {
    logic wrEn;    // store one byte
    logic rdEn;    // release one byte
    logic srcBuf;  // 1: byte comes from the buffer-read path
  } fifoStrobe_t;

  // low-water limit is the select code plus this base
  localparam int LOW_BASE = 2;
endpackage

// File: rtl/rx_level_fifo_dp.sv
module rx_level_fifo_dp
  import rx_level_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fifoStrobe_t                  strobe,
  input  logic [DW-1:0]                slvData,
  input  logic [DW-1:0]                bufData,
  output logic [DW-1:0]                popData,
  output logic [$clog2(DEPTH+1)-1:0]   occ
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW-1:0] wrPtrNxt, rdPtrNxt;
  logic [DW-1:0] wrData;

  assign wrData = strobe.srcBuf ? bufData : slvData;

  // pointer wrap: natural overflow for power-of-two depths, compare otherwise
  generate
    if (POW2) begin : g_wrapPow2
      assign wrPtrNxt = wrPtr + AW'(1);
      assign rdPtrNxt = rdPtr + AW'(1);
    end else begin : g_wrapCmp
      assign wrPtrNxt = (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      assign rdPtrNxt = (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      occ     <= '0;
      popData <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= wrPtrNxt;
      if (strobe.rdEn) begin
        rdPtr   <= rdPtrNxt;
        popData <= mem[rdPtr];
      end
      case ({strobe.wrEn, strobe.rdEn})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/rx_level_fifo_ctrl.sv
module rx_level_fifo_ctrl
  import rx_level_fifo_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int HIGH_MARK  = 7,
  parameter int SETTLE_CYC = 3000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         slvPush,
  input  logic                         bufRead,
  input  logic                         loadEn,
  input  logic                         pop,
  input  logic [1:0]                   lvlSel,
  input  logic                         fifoIntClr,
  input  logic [$clog2(DEPTH+1)-1:0]   occ,
  output fifoStrobe_t                  strobe,
  output logic                         flagHigh,
  output logic                         flagLow,
  output logic                         fifoInt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(SETTLE_CYC + 1);

  logic          isFull, isEmpty, bufPush, anyPush, restart, publish;
  logic          nextHigh, nextLow, riseEv;
  logic [CW-1:0] lowLim;
  logic [TW-1:0] settleCnt;

  assign isFull  = (occ == CW'(DEPTH));
  assign isEmpty = (occ == '0);
  assign bufPush = bufRead && loadEn;
  assign anyPush = slvPush || bufPush;

  // slave receiver has priority over the buffer-read copy
  assign strobe.rdEn   = pop && !isEmpty;
  assign strobe.wrEn   = anyPush && (!isFull || strobe.rdEn);
  assign strobe.srcBuf = !slvPush;

  assign restart = strobe.wrEn || strobe.rdEn;
  assign publish = (settleCnt == TW'(1)) && !restart;

  assign lowLim   = CW'(lvlSel) + CW'(LOW_BASE);
  assign nextHigh = (occ >= CW'(HIGH_MARK));
  assign nextLow  = (occ < lowLim);
  assign riseEv   = publish && ((nextHigh && !flagHigh) || (nextLow && !flagLow));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      flagHigh  <= 1'b0;
      flagLow   <= 1'b1;
      fifoInt   <= 1'b0;
    end else begin
      if (restart)              settleCnt <= TW'(SETTLE_CYC);
      else if (settleCnt != '0) settleCnt <= settleCnt - TW'(1);

      if (publish) begin
        flagHigh <= nextHigh;
        flagLow  <= nextLow;
      end

      if (riseEv)          fifoInt <= 1'b1;
      else if (fifoIntClr) fifoInt <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_level_fifo.sv
module rx_level_fifo
  import rx_level_fifo_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int HIGH_MARK  = 7,
  parameter int SETTLE_CYC = 3000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slvPush,
  input  logic [7:0] slvData,
  input  logic       bufRead,
  input  logic [7:0] bufData,
  input  logic       loadEn,
  input  logic       pop,
  output logic [7:0] popData,
  input  logic [1:0] lvlSel,
  output logic       flagHigh,
  output logic       flagLow,
  input  logic       fifoIntClr,
  output logic       fifoInt
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobe_t   strobe;
  logic [CW-1:0] occ;

  rx_level_fifo_ctrl #(
    .DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .slvPush(slvPush), .bufRead(bufRead),
    .loadEn(loadEn), .pop(pop), .lvlSel(lvlSel), .fifoIntClr(fifoIntClr),
    .occ(occ), .strobe(strobe), .flagHigh(flagHigh), .flagLow(flagLow),
    .fifoInt(fifoInt)
  );

  rx_level_fifo_dp #(.DEPTH(DEPTH), .DW(8)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slvData(slvData),
    .bufData(bufData), .popData(popData), .occ(occ)
  );
endmodule

// File: rtl/rx_level_fifo_chk.sv
module rx_level_fifo_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       slvPush,
  input logic                       bufRead,
  input logic                       loadEn,
  input logic                       pop,
  input logic                       fifoIntClr,
  input logic [$clog2(DEPTH+1)-1:0] occ,
  input logic [7:0]                 popData,
  input logic                       flagHigh,
  input logic                       flagLow,
  input logic                       fifoInt
);
  localparam int CW = $clog2(DEPTH + 1);

  // R4: occupancy never exceeds the depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CW'(DEPTH));

  // R4: push into full queue without pop keeps it full
  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CW'(DEPTH) && (slvPush || (bufRead && loadEn)) && !pop) |=> occ == CW'(DEPTH));

  // R5: pop on empty keeps the output byte
  a_r5_empty_hold: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0 && pop) |=> $stable(popData));

  // R8: an accepted push or pop never moves the flags on the following edge
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((pop && occ != '0) || (slvPush && occ != CW'(DEPTH)))
      |=> ($stable(flagHigh) && $stable(flagLow)));

  // R9: interrupt rises only with a rising published flag
  a_r9_int_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoInt) |-> ($rose(flagHigh) || $rose(flagLow)));

  // R10: clear works unless a flag rises on the same edge
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    fifoIntClr |=> (!fifoInt || $rose(flagHigh) || $rose(flagLow)));
endmodule

bind rx_level_fifo rx_level_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .slvPush(slvPush), .bufRead(bufRead),
  .loadEn(loadEn), .pop(pop), .fifoIntClr(fifoIntClr), .occ(occ),
  .popData(popData), .flagHigh(flagHigh), .flagLow(flagLow), .fifoInt(fifoInt)
);

// File: tb/rx_level_fifo_bench.sv
`timescale 1ns/1ps
module rx_level_fifo_bench;
  localparam int S = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic slvPush = 0, bufRead = 0, loadEn = 0, pop = 0, fifoIntClr = 0;
  logic [7:0] slvData = 0, bufData = 0;
  logic [1:0] lvlSel = 0;
  logic [7:0] popData;
  logic flagHigh, flagLow, fifoInt;

  int total = 0, bad = 0, occM = 0;

  always #2.5 clk = ~clk;

  rx_level_fifo #(.DEPTH(8), .HIGH_MARK(7), .SETTLE_CYC(S)) u_rx_level_fifo (
    .clk(clk), .rstN(rstN), .slvPush(slvPush), .slvData(slvData),
    .bufRead(bufRead), .bufData(bufData), .loadEn(loadEn), .pop(pop),
    .popData(popData), .lvlSel(lvlSel), .flagHigh(flagHigh), .flagLow(flagLow),
    .fifoIntClr(fifoIntClr), .fifoInt(fifoInt)
  );

  // {occupancy[3:0], lvlSel[1:0], expected low, expected high}
  localparam logic [7:0] VEC [12] = '{
    8'h12, 8'h20, 8'h26, 8'h34, 8'h3A, 8'h48,
    8'h4E, 8'h5C, 8'h6C, 8'h7D, 8'h81, 8'h1E };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushS(input logic [7:0] d);
    slvPush = 1; slvData = d;
    @(negedge clk);
    slvPush = 0;
    if (occM < 8) occM++;
  endtask

  task automatic popT();
    pop = 1;
    @(negedge clk);
    pop = 0;
    if (occM > 0) occM--;
  endtask

  task automatic clrPulse();
    fifoIntClr = 1;
    @(negedge clk);
    fifoIntClr = 0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 popData", popData, 8'h00);
    chk("R1 flagLow", {7'd0, flagLow}, 8'h01);
    chk("R1 flagHigh", {7'd0, flagHigh}, 8'h00);
    chk("R1 fifoInt", {7'd0, fifoInt}, 8'h00);
    rstN = 1;
    @(negedge clk);

    // R2 arrival order
    pushS(8'hA1); pushS(8'hA2); pushS(8'hA3);
    popT(); chk("R2 first", popData, 8'hA1);
    popT(); chk("R2 second", popData, 8'hA2);
    popT(); chk("R2 third", popData, 8'hA3);

    // R3 load-enable gating, R5 empty pop
    pushS(8'h11);
    bufRead = 1; bufData = 8'h55; loadEn = 0;
    @(negedge clk); bufRead = 0;
    popT(); chk("R3 gated", popData, 8'h11);
    popT(); chk("R5 empty pop", popData, 8'h11);
    loadEn = 1; bufRead = 1; bufData = 8'h66;
    @(negedge clk); bufRead = 0; occM++;
    popT(); chk("R3 buffer load", popData, 8'h66);
    // R3 collision: slave wins
    bufRead = 1; bufData = 8'h88;
    pushS(8'h77); bufRead = 0; loadEn = 0;
    popT(); chk("R3 slave priority", popData, 8'h77);
    popT(); chk("R3 buffer byte dropped", popData, 8'h77);

    // R11 push and pop together
    pushS(8'h31);
    pop = 1; pushS(8'h32); pop = 0; occM--;
    chk("R11 pop side", popData, 8'h31);
    popT(); chk("R11 push side", popData, 8'h32);
    popT(); chk("R11 occupancy kept", popData, 8'h32);

    // R4 full drop
    for (int i = 0; i < 9; i++) pushS(8'h20 + 8'(i));
    for (int i = 0; i < 8; i++) begin
      popT(); chk("R4 order", popData, 8'h20 + 8'(i));
    end
    popT(); chk("R4 ninth dropped", popData, 8'h27);

    // R8 / R9 settle timing of high flag
    lvlSel = 2'b00;
    repeat (S + 2) @(negedge clk);
    clrPulse();
    for (int i = 0; i < 7; i++) pushS(8'h40);
    repeat (S - 1) @(negedge clk);
    chk("R8 high held", {7'd0, flagHigh}, 8'h00);
    chk("R9 int not yet", {7'd0, fifoInt}, 8'h00);
    @(negedge clk);
    chk("R8 R6 high published", {7'd0, flagHigh}, 8'h01);
    chk("R9 int set", {7'd0, fifoInt}, 8'h01);
    clrPulse();
    chk("R10 clear", {7'd0, fifoInt}, 8'h00);

    // R10 set and clear on the same edge
    for (int i = 0; i < 6; i++) popT();
    repeat (S - 1) @(negedge clk);
    chk("R8 low held", {7'd0, flagLow}, 8'h00);
    fifoIntClr = 1;
    @(negedge clk);
    fifoIntClr = 0;
    chk("R7 low published", {7'd0, flagLow}, 8'h01);
    chk("R10 set wins", {7'd0, fifoInt}, 8'h01);
    clrPulse();
    chk("R10 later clear", {7'd0, fifoInt}, 8'h00);

    // R6 / R7 threshold table
    for (int v = 0; v < 12; v++) begin
      int tgt;
      tgt = int'(VEC[v][7:4]);
      while (occM < tgt) pushS(8'hC0);
      while (occM > tgt) popT();
      lvlSel = VEC[v][3:2];
      pop = 1; pushS(8'hC1); pop = 0; occM--;
      repeat (S + 2) @(negedge clk);
      chk("R7 table low", {7'd0, flagLow}, {7'd0, VEC[v][1]});
      chk("R6 table high", {7'd0, flagHigh}, {7'd0, VEC[v][0]});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule